// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Control Registers

This block holds the software-visible control state for a two-channel bus-master disk DMA function. It sits in a 16-byte I/O window reached over a simple register bus. Each access carries a dword index, four byte-lane enables and a 32-bit data word, so software can use byte, word or doubleword accesses. One access may touch several registers at once. Each channel owns a command byte, a status byte and a 32-bit descriptor table pointer. The DMA engine, descriptor fetching and the drive interface sit outside this block.

Each channel has a small run-control state machine with two states. ST_IDLE means the start bit reads 0, and ST_RUN means it reads 1. Three transitions leave a state:
- LAUNCH goes from ST_IDLE to ST_RUN when a 1 is written to the start bit. It emits a one-cycle start pulse.
- STOP goes from ST_RUN to ST_IDLE when a 0 is written to the start bit. It emits a one-cycle halt pulse, which tells the engine to drop all transfer state.
- ABORT is the same move as STOP, but it fires when the engine reports the channel active and no interrupt has been latched. It emits the halt pulse together with an abort pulse.

Every other write to the start bit leaves the state unchanged. The engine returns three indications per channel: a level for active, an error event and an interrupt event. These feed the status byte.

Top module: `dmactl_regs`

## Requirements
- R1: The dword index selects the register group. Index 0 holds primary command/status, 1 holds the primary pointer, 2 holds secondary command/status and 3 holds the secondary pointer. In a command/status dword, lane 0 is the command byte, lane 2 is the status byte, and lanes 1 and 3 are reserved.
- R2: A write changes only the byte lanes whose enable bit is set. A read returns the whole dword on `rd_data`, with `rd_valid` high, in the cycle after the request.
- R3: Command bits 7:4 and 2:1 and both reserved bytes always read 0, and writes to them change nothing.
- R4: Command bit 3 is a read-write direction bit (1 = memory writes). It drives `dir_write` for its channel.
- R5: Writing 1 to command bit 0 while it reads 0 raises `start_pulse` for exactly the one cycle after the write. Writing 1 while it already reads 1 produces no pulse.
- R6: Writing 0 to command bit 0 while it reads 1 raises `halt_pulse` for one cycle. Writing 0 while it reads 0 produces no pulse.
- R7: A halt is also flagged with `abort_pulse` when, at the write, `eng_active` is high and status bit 2 is 0. Otherwise `abort_pulse` stays low.
- R8: After reset, all command, status and pointer registers read 0 and no pulse is raised.
- R9: Status bit 1 is set by `eng_error` and status bit 2 by `eng_irq`. Writing 1 clears the bit and writing 0 leaves it alone. An engine event wins over a clear in the same cycle.
- R10: Status bit 0 reads the live `eng_active` level. Bits 6:5 are plain read-write flags, and bits 7, 4 and 3 read 0.
- R11: Each descriptor pointer is read-write per byte lane, and its bits 1:0 always read 0.
- R12: The two channels are independent. A write to one never changes the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dw_addr | input | 2 | Dword index in the 16-byte window (byte offset bits 3:2) |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| eng_active | input | 2 | Engine reports channel active, one bit per channel |
| eng_error | input | 2 | Engine error event, one bit per channel |
| eng_irq | input | 2 | Engine interrupt event, one bit per channel |
| dir_write | output | 2 | Transfer direction per channel |
| start_pulse | output | 2 | One-cycle launch request per channel |
| halt_pulse | output | 2 | One-cycle stop-and-discard request per channel |
| abort_pulse | output | 2 | One-cycle abort flag per channel |
| desc_ptr_pri | output | 32 | Primary descriptor table pointer |
| desc_ptr_sec | output | 32 | Secondary descriptor table pointer |

## Verification
The hardest case to reach from the ports is the ABORT transition. To get there, the channel must be in ST_RUN, the engine must be holding `eng_active` high, and the latched interrupt bit must be clear, all at the moment software writes 0 to the start bit. The bench first launches the channel, then raises `eng_active` and clears the start bit. It then repeats the sequence with an `eng_irq` event injected before the stop, so the same write must give a plain STOP. A related corner is an error event arriving in the same cycle as a write-one-to-clear. The bench drives both on one edge and reads the status back.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
    localparam int NUM_CH   = 2;
    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int DWA_W    = 2;

    // command byte fields
    localparam int CMD_START = 0;
    localparam int CMD_DIR   = 3;
    // status byte fields
    localparam int ST_ACT    = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_IRQ    = 2;
    localparam int ST_FLG_LO = 5;
    localparam int ST_FLG_HI = 6;
    // lanes within a command/status dword
    localparam int LANE_CMD  = 0;
    localparam int LANE_STAT = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/dmactl_run_fsm.sv
module dmactl_run_fsm
    import dmactl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic       wd_start,
    input  logic       wd_dir,
    input  logic       eng_active,
    input  logic       irq_flag,
    output logic [7:0] cmd_rd,
    output logic       dir_write,
    output logic       start_pulse,
    output logic       halt_pulse,
    output logic       abort_pulse
);
    run_state_t state_q, state_d;
    logic launch_d, stop_d, abort_d;
    logic dir_q;

    // next-state and transition decode
    always_comb begin
        state_d  = state_q;
        launch_d = 1'b0;
        stop_d   = 1'b0;
        abort_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_we && wd_start) begin
                    state_d  = ST_RUN;
                    launch_d = 1'b1;
                end
            end
            ST_RUN: begin
                if (cmd_we && !wd_start) begin
                    state_d = ST_IDLE;
                    stop_d  = 1'b1;
                    abort_d = eng_active && !irq_flag;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            halt_pulse  <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            start_pulse <= launch_d;
            halt_pulse  <= stop_d;
            abort_pulse <= abort_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q <= 1'b0;
        else if (cmd_we) dir_q <= wd_dir;
    end

    always_comb begin
        cmd_rd            = 8'h00;
        cmd_rd[CMD_DIR]   = dir_q;
        cmd_rd[CMD_START] = (state_q == ST_RUN);
    end
    assign dir_write = dir_q;

    // R5: a start pulse only accompanies the idle-to-run move
    a_r5_start_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (state_q == ST_RUN && $past(state_q) == ST_IDLE));
    // R6: a halt pulse only follows a run-to-idle move
    a_r6_halt_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |-> (state_q == ST_IDLE && $past(state_q) == ST_RUN));
    // R7: abort is always a qualified halt
    a_r7_abort_is_halt: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> halt_pulse);
    // R5: pulses last one cycle
    a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
endmodule

// File: rtl/dmactl_status.sv
module dmactl_status
    import dmactl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_we,
    input  logic       wd_err_clr,
    input  logic       wd_irq_clr,
    input  logic [1:0] wd_flags,
    input  logic       eng_active,
    input  logic       eng_error,
    input  logic       eng_irq,
    output logic [7:0] stat_rd,
    output logic       irq_flag
);
    logic       err_q, irq_q;
    logic [1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        err_q <= 1'b0;
        else if (eng_error)                err_q <= 1'b1;
        else if (stat_we && wd_err_clr)    err_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        irq_q <= 1'b0;
        else if (eng_irq)                  irq_q <= 1'b1;
        else if (stat_we && wd_irq_clr)    irq_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flags_q <= 2'b00;
        else if (stat_we) flags_q <= wd_flags;
    end

    always_comb begin
        stat_rd                      = 8'h00;
        stat_rd[ST_ACT]              = eng_active;
        stat_rd[ST_ERR]              = err_q;
        stat_rd[ST_IRQ]              = irq_q;
        stat_rd[ST_FLG_HI:ST_FLG_LO] = flags_q;
    end
    assign irq_flag = irq_q;

    // R9: an engine event always lands, even against a clear
    a_r9_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
        eng_irq |=> irq_q);
    a_r9_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        eng_error |=> err_q);
    // R9: a one-write without a competing event clears
    a_r9_irq_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && wd_irq_clr && !eng_irq) |=> !irq_q);
endmodule

// File: rtl/dmactl_ptr.sv
module dmactl_ptr
    import dmactl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] ptr_rd
);
    logic [DATA_W-1:2] ptr_q;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        if (ln == 0) begin : g_low
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                ptr_q[7:2] <= '0;
                else if (ptr_wr && be[0])  ptr_q[7:2] <= wd[7:2];
            end
        end else begin : g_full
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                 ptr_q[8*ln+7:8*ln] <= '0;
                else if (ptr_wr && be[ln])  ptr_q[8*ln+7:8*ln] <= wd[8*ln+7:8*ln];
            end
        end
    end

    assign ptr_rd = {ptr_q, 2'b00};
endmodule

// File: rtl/dmactl_regs.sv
module dmactl_regs
    import dmactl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DWA_W-1:0]  req_dw_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] eng_active,
    input  logic [NUM_CH-1:0] eng_error,
    input  logic [NUM_CH-1:0] eng_irq,
    output logic [NUM_CH-1:0] dir_write,
    output logic [NUM_CH-1:0] start_pulse,
    output logic [NUM_CH-1:0] halt_pulse,
    output logic [NUM_CH-1:0] abort_pulse,
    output logic [DATA_W-1:0] desc_ptr_pri,
    output logic [DATA_W-1:0] desc_ptr_sec
);
    localparam int CH_BIT  = 1;   // index bit selecting the channel
    localparam int PTR_BIT = 0;   // index bit selecting the pointer dword

    logic [DATA_W-1:0] cs_word [NUM_CH];
    logic [DATA_W-1:0] ptr_word[NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic       hit, cs_hit, cmd_we, stat_we, irq_flag;
        logic [7:0] cmd_rd, stat_rd;

        assign hit     = req_valid && req_write && (req_dw_addr[CH_BIT] == ch[0]);
        assign cs_hit  = hit && !req_dw_addr[PTR_BIT];
        assign cmd_we  = cs_hit && req_be[LANE_CMD];
        assign stat_we = cs_hit && req_be[LANE_STAT];

        dmactl_run_fsm u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd_we      (cmd_we),
            .wd_start    (req_wdata[8*LANE_CMD + CMD_START]),
            .wd_dir      (req_wdata[8*LANE_CMD + CMD_DIR]),
            .eng_active  (eng_active[ch]),
            .irq_flag    (irq_flag),
            .cmd_rd      (cmd_rd),
            .dir_write   (dir_write[ch]),
            .start_pulse (start_pulse[ch]),
            .halt_pulse  (halt_pulse[ch]),
            .abort_pulse (abort_pulse[ch])
        );

        dmactl_status u_stat (
            .clk        (clk),
            .rst_n      (rst_n),
            .stat_we    (stat_we),
            .wd_err_clr (req_wdata[8*LANE_STAT + ST_ERR]),
            .wd_irq_clr (req_wdata[8*LANE_STAT + ST_IRQ]),
            .wd_flags   (req_wdata[8*LANE_STAT + ST_FLG_HI : 8*LANE_STAT + ST_FLG_LO]),
            .eng_active (eng_active[ch]),
            .eng_error  (eng_error[ch]),
            .eng_irq    (eng_irq[ch]),
            .stat_rd    (stat_rd),
            .irq_flag   (irq_flag)
        );

        dmactl_ptr u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ptr_wr (hit && req_dw_addr[PTR_BIT]),
            .be     (req_be),
            .wd     (req_wdata),
            .ptr_rd (ptr_word[ch])
        );

        assign cs_word[ch] = {8'h00, stat_rd, 8'h00, cmd_rd};
    end

    assign desc_ptr_pri = ptr_word[0];
    assign desc_ptr_sec = ptr_word[1];

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        if (req_dw_addr[PTR_BIT]) rd_mux = ptr_word[req_dw_addr[CH_BIT]];
        else                      rd_mux = cs_word[req_dw_addr[CH_BIT]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rd_data <= rd_mux;
        end
    end

    // R12: pulses of one channel never come from a write aimed at the other
    a_r12_ch_isolation: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_dw_addr[CH_BIT]) |=> !start_pulse[0] && !halt_pulse[0]);
    // R2: read data strobe is a single cycle per read request
    a_r2_rd_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid) && !$past(req_write));
endmodule

// File: tb/sim_dmactl_regs.sv
module sim_dmactl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_dw_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [1:0]  eng_active = '0, eng_error = '0, eng_irq = '0;
    logic [1:0]  dir_write, start_pulse, halt_pulse, abort_pulse;
    logic [31:0] desc_ptr_pri, desc_ptr_sec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dmactl_regs u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_dw_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_be = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_dw_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
        n_chk++;
        if (rd_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R2: rd_valid actual %b expected 1", rd_valid);
        end
    endtask

    // {op(1=write), dword index, byte enables, data, expected read}
    localparam int NV = 15;
    localparam logic [70:0] VEC [NV] = '{
        {1'b1, 2'd0, 4'hF, 32'hFFFF_FF08, 32'h0},           // R3 R10 reserved ignored
        {1'b0, 2'd0, 4'h0, 32'h0,         32'h0060_0008},
        {1'b1, 2'd1, 4'hF, 32'h1234_5677, 32'h0},           // R11
        {1'b0, 2'd1, 4'h0, 32'h0,         32'h1234_5674},
        {1'b1, 2'd1, 4'h2, 32'hFFFF_ABFF, 32'h0},           // R2 single lane
        {1'b0, 2'd1, 4'h0, 32'h0,         32'h1234_AB74},
        {1'b1, 2'd2, 4'h1, 32'h0000_00FE, 32'h0},           // R1 secondary cmd
        {1'b0, 2'd2, 4'h0, 32'h0,         32'h0000_0008},
        {1'b1, 2'd3, 4'hC, 32'hDEAD_BEEF, 32'h0},           // R2 upper half
        {1'b0, 2'd3, 4'h0, 32'h0,         32'hDEAD_0000},
        {1'b0, 2'd0, 4'h0, 32'h0,         32'h0060_0008},   // R12
        {1'b1, 2'd0, 4'h4, 32'h0000_0000, 32'h0},           // R10 clear flags
        {1'b0, 2'd0, 4'h0, 32'h0,         32'h0000_0008},
        {1'b1, 2'd0, 4'h1, 32'h0000_0000, 32'h0},
        {1'b0, 2'd0, 4'h0, 32'h0,         32'h0000_0000}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            check("R8 reset read", d, 32'h0);
        end
        check("R8 reset pulses", {26'h0, start_pulse, halt_pulse, abort_pulse}, 32'h0);

        // R1/R2/R3/R10/R11/R12 table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][70]) wr(VEC[i][69:68], VEC[i][67:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][69:68], d);
                check($sformatf("R1/R2 vector %0d", i), d, VEC[i][31:0]);
            end
        end

        // R4 direction output
        check("R4 dir_write", {30'h0, dir_write}, 32'h2);

        // R5 launch
        wr(2'd0, 4'h1, 32'h1);
        check("R5 start pulse", {30'h0, start_pulse}, 32'h1);
        @(negedge clk);
        check("R5 start single cycle", {30'h0, start_pulse}, 32'h0);
        wr(2'd0, 4'h1, 32'h1);
        check("R5 no restart", {30'h0, start_pulse}, 32'h0);

        // R6 normal stop, then stop when idle
        wr(2'd0, 4'h1, 32'h0);
        check("R6 halt pulse", {30'h0, halt_pulse}, 32'h1);
        check("R7 no abort when inactive", {30'h0, abort_pulse}, 32'h0);
        wr(2'd0, 4'h1, 32'h0);
        check("R6 no halt when idle", {30'h0, halt_pulse}, 32'h0);

        // R7 abort
        wr(2'd0, 4'h1, 32'h1);
        eng_active = 2'b01;
        wr(2'd0, 4'h1, 32'h0);
        check("R7 abort halt", {30'h0, halt_pulse}, 32'h1);
        check("R7 abort pulse", {30'h0, abort_pulse}, 32'h1);

        // R7 stop after interrupt is not an abort
        wr(2'd0, 4'h1, 32'h1);
        @(negedge clk); eng_irq = 2'b01;
        @(negedge clk); eng_irq = 2'b00;
        wr(2'd0, 4'h1, 32'h0);
        check("R7 stop with irq halts", {30'h0, halt_pulse}, 32'h1);
        check("R7 stop with irq no abort", {30'h0, abort_pulse}, 32'h0);

        // R9/R10 status bits: active, irq latched
        rd(2'd0, d);
        check("R9 irq and active read", d, 32'h0005_0000);
        wr(2'd0, 4'h4, 32'h0004_0000);
        rd(2'd0, d);
        check("R9 irq w1c", d, 32'h0001_0000);
        eng_active = 2'b00;

        // R9 error on secondary, write zero, set beats clear
        @(negedge clk); eng_error = 2'b10;
        @(negedge clk); eng_error = 2'b00;
        wr(2'd2, 4'h4, 32'h0);
        rd(2'd2, d);
        check("R9 zero write keeps err", d, 32'h0002_0008);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_dw_addr = 2'd2; req_be = 4'h4;
        req_wdata = 32'h0002_0000; eng_error = 2'b10;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_be = '0; eng_error = 2'b00;
        rd(2'd2, d);
        check("R9 set wins over clear", d, 32'h0002_0008);
        wr(2'd2, 4'h4, 32'h0002_0000);
        rd(2'd2, d);
        check("R9 err cleared", d, 32'h0000_0008);
        rd(2'd0, d);
        check("R12 primary untouched", d, 32'h0000_0000);
        check("R11 pointer ports", desc_ptr_pri ^ desc_ptr_sec, 32'h1234_AB74 ^ 32'hDEAD_0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule